// File: doc/BRIEF.md
# Descriptor-Driven DMA Channel Engine

This block is one DMA channel. It holds a transfer descriptor in a small register file that software writes and reads over a word-wide configuration port. The descriptor holds a source address, a destination address, a per-request byte count, a begin iteration count, a current iteration count and a control/status word. Each service request performs one minor loop. A request comes either from software setting a start bit or from a hardware request line while the request enable is on. The engine checks the descriptor and copies the byte count one 32-bit word at a time: a read from the source, then a write to the destination. It then writes the advanced addresses and the decremented iteration count back into the descriptor.

The minor loops nest inside a major loop. When the current count runs out, the engine reloads it from the begin count, raises the done flag, and can drop the hardware request enable. It can also signal half-way and completion interrupts. A descriptor that cannot be executed sets a sticky error flag and causes no bus traffic. A scatter/gather bit is stored and read back but has no effect.

Descriptor word map on `cfg_addr`: 0 source address, 1 destination address, 2 byte count, 3 begin count (low 16 bits), 4 current count (low 16 bits), 5 control/status, 6 hardware request enable (bit 0).

Top module: `dma_channel`

## Requirements
- R1: After reset, `active`, `done`, `cfg_err`, `irq_half`, `irq_major`, `mem_rd` and `mem_wr` are 0, and the control/status word and the current count read as 0.
- R2: Writing 1 to control bit 0 (start) starts one minor loop. The start bit reads 0 once the loop begins. `active` stays 1 from the cycle after the start bit is latched until the loop ends.
- R3: A one-cycle `hw_req` pulse starts a minor loop only when word 6 bit 0 is 1. Otherwise it is ignored: no bus cycle, no `active`, and the current count is unchanged.
- R4: A minor loop makes byte-count/4 beats. Each beat reads the source word and then writes that data to the destination. Both addresses advance by 4 per beat.
- R5: At the end of each minor loop, the source and destination words hold the addresses advanced by the byte count. The next minor loop continues from them.
- R6: Each minor loop decrements the current count by 1. The loop that brings it from 1 to 0 instead reloads it with the begin count.
- R7: Control bit 5 (done) becomes 1 at major-loop completion and stays 1 until software writes 1 to bit 5.
- R8: With control bit 3 set, major-loop completion clears the hardware request enable, so later `hw_req` pulses are ignored.
- R9: With control bit 1 set, `irq_half` pulses for one cycle after the minor loop whose decremented count equals begin count/2 (integer division, not at completion). With control bit 2 set, `irq_major` pulses for one cycle at major-loop completion.
- R10: A byte count that is zero or not a multiple of 4, a zero begin or current count, or a source or destination address that is not 4-byte aligned is a configuration error. It sets `cfg_err` and control bit 7, makes no bus cycle, drops `active` and leaves the descriptor unchanged. Writing 1 to bit 7 clears the error.
- R11: Control bit 4 (scatter/gather) is stored and read back unchanged and does not alter a transfer.
- R12: `active` is high for exactly 2·(byte count/4)+2 cycles per minor loop. After a `hw_req` pulse it rises at the first clock edge that samples the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Descriptor word write strobe |
| cfg_addr | input | 3 | Descriptor word select |
| cfg_wdata | input | 32 | Descriptor write data |
| cfg_rdata | output | 32 | Descriptor read data (combinational) |
| hw_req | input | 1 | Hardware service request |
| mem_rd | output | 1 | Memory read strobe, data expected on `mem_rdata` next cycle |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |
| active | output | 1 | Channel executing a minor loop |
| done | output | 1 | Major loop complete |
| cfg_err | output | 1 | Sticky configuration error |
| irq_half | output | 1 | Half-way interrupt pulse |
| irq_major | output | 1 | Completion interrupt pulse |

## Verification
A hardware pulse makes `active` rise at the edge that samples it. A software start takes one more edge, because the start bit is latched first. The loop then holds `active` for 2·beats+2 cycles, and the written-back addresses, count, done flag and interrupt pulses appear at the edge where `active` falls. The bench changes inputs on falling edges and counts the falling edges during which `active` is high, comparing that count with the formula. It reads the descriptor only after `active` has dropped. Interrupt pulses and bus reads are tallied on every rising edge and compared as deltas per sweep. Those deltas are computed from the byte count and the begin count.

// File: rtl/dma_channel.sv
module dma_channel #(
  parameter int CW = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        hw_req,
  output logic        mem_rd,
  output logic        mem_wr,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  output logic        active,
  output logic        done,
  output logic        cfg_err,
  output logic        irq_half,
  output logic        irq_major
);
  typedef enum logic [2:0] {S_IDLE, S_CHK, S_RD, S_WR, S_WB} state_t;
  state_t state;

  logic [31:0] src_q, dst_q, nb_q, wsa, wda, rem;
  logic [CW-1:0] biter_q, citer_q;
  logic start_q, ih_q, im_q, dreq_q, sg_q, done_q, reqen_q, err_q;

  logic bad;
  assign bad = (nb_q == 0) || (nb_q[1:0] != 2'b00) || (biter_q == 0) || (citer_q == 0) ||
               (src_q[1:0] != 2'b00) || (dst_q[1:0] != 2'b00);

  logic [CW-1:0] citer_dec;
  assign citer_dec = citer_q - 1'b1;

  assign active    = (state != S_IDLE);
  assign done      = done_q;
  assign cfg_err   = err_q;
  assign mem_rd    = (state == S_RD);
  assign mem_wr    = (state == S_WR);
  assign mem_addr  = (state == S_WR) ? wda : wsa;
  assign mem_wdata = mem_rdata;

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      3'd0: cfg_rdata = src_q;
      3'd1: cfg_rdata = dst_q;
      3'd2: cfg_rdata = nb_q;
      3'd3: cfg_rdata = 32'(biter_q);
      3'd4: cfg_rdata = 32'(citer_q);
      3'd5: cfg_rdata = {24'd0, err_q, active, done_q, sg_q, dreq_q, im_q, ih_q, start_q};
      3'd6: cfg_rdata = {31'd0, reqen_q};
      default: cfg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      src_q <= '0; dst_q <= '0; nb_q <= '0; wsa <= '0; wda <= '0; rem <= '0;
      biter_q <= '0; citer_q <= '0;
      start_q <= 1'b0; ih_q <= 1'b0; im_q <= 1'b0; dreq_q <= 1'b0; sg_q <= 1'b0;
      done_q <= 1'b0; reqen_q <= 1'b0; err_q <= 1'b0;
      irq_half <= 1'b0; irq_major <= 1'b0;
    end else begin
      irq_half  <= 1'b0;
      irq_major <= 1'b0;
      if (cfg_we) begin
        case (cfg_addr)
          3'd0: src_q <= cfg_wdata;
          3'd1: dst_q <= cfg_wdata;
          3'd2: nb_q <= cfg_wdata;
          3'd3: biter_q <= cfg_wdata[CW-1:0];
          3'd4: citer_q <= cfg_wdata[CW-1:0];
          3'd5: begin
            start_q <= cfg_wdata[0];
            ih_q    <= cfg_wdata[1];
            im_q    <= cfg_wdata[2];
            dreq_q  <= cfg_wdata[3];
            sg_q    <= cfg_wdata[4];
            if (cfg_wdata[5]) done_q <= 1'b0;
            if (cfg_wdata[7]) err_q <= 1'b0;
          end
          3'd6: reqen_q <= cfg_wdata[0];
          default: ;
        endcase
      end
      case (state)
        S_IDLE: if (start_q || (hw_req && reqen_q)) begin
          start_q <= 1'b0;
          state   <= S_CHK;
        end
        S_CHK: if (bad) begin
          err_q <= 1'b1;
          state <= S_IDLE;
        end else begin
          wsa   <= src_q;
          wda   <= dst_q;
          rem   <= nb_q;
          state <= S_RD;
        end
        S_RD: state <= S_WR;
        S_WR: begin
          wsa   <= wsa + 32'd4;
          wda   <= wda + 32'd4;
          rem   <= rem - 32'd4;
          state <= (rem == 32'd4) ? S_WB : S_RD;
        end
        S_WB: begin
          src_q <= wsa;
          dst_q <= wda;
          if (citer_q == 1) begin
            citer_q   <= biter_q;
            done_q    <= 1'b1;
            irq_major <= im_q;
            if (dreq_q) reqen_q <= 1'b0;
          end else begin
            citer_q  <= citer_dec;
            irq_half <= ih_q && (citer_dec == (biter_q >> 1));
          end
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module dma_channel_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          active,
  input logic          done,
  input logic          cfg_err,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic [1:0]    addr_lo,
  input logic          irq_half,
  input logic          irq_major,
  input logic          start_q,
  input logic [CW-1:0] citer_q,
  input logic [CW-1:0] biter_q
);
  assert_bus_needs_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> active);
  assert_word_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> (addr_lo == 2'b00));
  assert_start_cleared_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !$past(active)) |-> !start_q);
  assert_reload_on_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (citer_q == biter_q));
  assert_err_no_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_err) |-> (!active && !mem_rd && !mem_wr));
  assert_major_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_major |-> done);
  assert_irq_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_half, irq_major}));
endmodule

bind dma_channel dma_channel_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .active(active), .done(done), .cfg_err(cfg_err),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .addr_lo(mem_addr[1:0]),
  .irq_half(irq_half), .irq_major(irq_major), .start_q(start_q),
  .citer_q(citer_q), .biter_q(biter_q)
);

// File: tb/tb_dma_channel.sv
`timescale 1ns/1ps
module tb_dma_channel;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, hw_req = 0;
  logic [2:0] cfg_addr = 0;
  logic [31:0] cfg_wdata = 0, cfg_rdata;
  logic mem_rd, mem_wr;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic active, done, cfg_err, irq_half, irq_major;

  always #2 clk = ~clk;

  dma_channel dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .hw_req(hw_req), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .active(active),
    .done(done), .cfg_err(cfg_err), .irq_half(irq_half), .irq_major(irq_major)
  );

  logic [31:0] mem [64];
  logic tb_we = 0;
  logic [5:0] tb_wa = 0;
  logic [31:0] tb_wd = 0;
  int n_rd = 0, n_half = 0, n_major = 0, n_cyc = 0;
  int checks = 0, fails = 0;

  always @(posedge clk) begin
    n_cyc <= n_cyc + 1;
    if (mem_rd) begin
      mem_rdata <= mem[mem_addr[7:2]];
      n_rd <= n_rd + 1;
    end
    if (tb_we) mem[tb_wa] <= tb_wd;
    else if (mem_wr) mem[mem_addr[7:2]] <= mem_wdata;
    if (irq_half) n_half <= n_half + 1;
    if (irq_major) n_major <= n_major + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    cfg_addr = a; #1; d = cfg_rdata;
  endtask

  task automatic mload(input int idx, input logic [31:0] d);
    @(negedge clk); tb_we = 1; tb_wa = 6'(idx); tb_wd = d;
    @(negedge clk); tb_we = 0;
  endtask

  task automatic run_hw(output int cyc);
    @(negedge clk); hw_req = 1;
    @(negedge clk); hw_req = 0;
    cyc = 0;
    while (active) begin cyc++; @(negedge clk); end
  endtask

  task automatic run_sw(input logic [31:0] ctrl, output int cyc);
    wr(3'd5, ctrl | 32'h1);
    @(negedge clk);
    cyc = 0;
    while (active) begin cyc++; @(negedge clk); end
  endtask

  function automatic logic [31:0] pat(input int id, input int i);
    return {8'(id), 8'h5A, 16'(i * 7 + 3)};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int cyc, h0, m0, r0, id, words;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 active", {31'd0, active}, 0);
    chk("R1 done", {31'd0, done}, 0);
    chk("R1 cfg_err", {31'd0, cfg_err}, 0);
    chk("R1 irqs", {30'd0, irq_half, irq_major}, 0);
    chk("R1 bus", {30'd0, mem_rd, mem_wr}, 0);
    rd(3'd5, v); chk("R1 ctrl", v, 0);
    rd(3'd4, v); chk("R1 citer", v, 0);

    id = 0;
    for (int nb = 4; nb <= 12; nb += 4) begin
      for (int bi = 1; bi <= 4; bi++) begin
        id++;
        words = nb * bi / 4;
        for (int i = 0; i < words; i++) mload(i, pat(id, i));
        for (int i = 0; i < words; i++) mload(32 + i, 32'h0);
        wr(3'd0, 32'h0); wr(3'd1, 32'h80); wr(3'd2, 32'(nb));
        wr(3'd3, 32'(bi)); wr(3'd4, 32'(bi)); wr(3'd6, 32'h1);
        wr(3'd5, 32'hA6);
        h0 = n_half; m0 = n_major; r0 = n_rd;
        for (int k = 1; k <= bi; k++) begin
          if (k % 2 == 1) run_hw(cyc); else run_sw(32'h06, cyc);
          chk("R12 active length", 32'(cyc), 32'(2 * (nb / 4) + 2));
          rd(3'd4, v); chk("R6 citer", v, (k == bi) ? 32'(bi) : 32'(bi - k));
          rd(3'd5, v); chk("R7 done bit", {31'd0, v[5]}, (k == bi) ? 1 : 0);
          chk("R2 start self-clear", {31'd0, v[0]}, 0);
        end
        rd(3'd0, v); chk("R5 src writeback", v, 32'(nb * bi));
        rd(3'd1, v); chk("R5 dst writeback", v, 32'h80 + 32'(nb * bi));
        for (int i = 0; i < words; i++) chk("R4 data copy", mem[32 + i], pat(id, i));
        chk("R4 beat count", 32'(n_rd - r0), 32'(words));
        @(negedge clk);
        chk("R9 half irq", 32'(n_half - h0), (bi >= 2) ? 1 : 0);
        chk("R9 major irq", 32'(n_major - m0), 1);
      end
    end

    // R7 done clear
    wr(3'd5, 32'h20);
    chk("R7 done cleared", {31'd0, done}, 0);

    // R3 request ignored while disabled
    wr(3'd6, 32'h0);
    rd(3'd4, v);
    r0 = n_rd;
    run_hw(cyc);
    chk("R3 no activity", 32'(cyc), 0);
    chk("R3 no bus", 32'(n_rd - r0), 0);
    begin logic [31:0] v2; rd(3'd4, v2); chk("R3 citer unchanged", v2, v); end

    // R8 request disable at completion
    wr(3'd0, 32'h0); wr(3'd1, 32'h80); wr(3'd2, 32'd4);
    wr(3'd3, 32'd2); wr(3'd4, 32'd2); wr(3'd6, 32'h1); wr(3'd5, 32'hA8);
    run_hw(cyc);
    rd(3'd6, v); chk("R8 enable kept mid-loop", v, 1);
    run_hw(cyc);
    rd(3'd6, v); chk("R8 enable cleared", v, 0);
    run_hw(cyc);
    chk("R8 later request ignored", 32'(cyc), 0);

    // R10 configuration errors
    r0 = n_rd;
    wr(3'd5, 32'hA0); wr(3'd2, 32'd0);
    run_sw(32'h0, cyc);
    chk("R10 zero bytes err", {31'd0, cfg_err}, 1);
    rd(3'd5, v); chk("R10 err bit", {31'd0, v[7]}, 1);
    chk("R10 active dropped", {31'd0, active}, 0);
    chk("R10 no bus", 32'(n_rd - r0), 0);
    wr(3'd5, 32'h80);
    chk("R10 err cleared", {31'd0, cfg_err}, 0);
    wr(3'd2, 32'd4); wr(3'd0, 32'h2);
    run_sw(32'h0, cyc);
    chk("R10 misaligned src", {31'd0, cfg_err}, 1);
    rd(3'd0, v); chk("R10 src unchanged", v, 32'h2);
    wr(3'd5, 32'h80); wr(3'd0, 32'h0); wr(3'd2, 32'd6);
    run_sw(32'h0, cyc);
    chk("R10 odd byte count", {31'd0, cfg_err}, 1);
    wr(3'd5, 32'h80); wr(3'd2, 32'd4); wr(3'd3, 32'd0);
    run_sw(32'h0, cyc);
    chk("R10 zero begin count", {31'd0, cfg_err}, 1);
    chk("R10 no bus overall", 32'(n_rd - r0), 0);

    // R11 scatter/gather bit stored, no effect
    wr(3'd5, 32'hB0); wr(3'd3, 32'd3); wr(3'd4, 32'd3);
    wr(3'd0, 32'h10); wr(3'd1, 32'h90); wr(3'd2, 32'd8);
    rd(3'd5, v); chk("R11 sg readback", {31'd0, v[4]}, 1);
    run_sw(32'h10, cyc);
    chk("R11 normal length", 32'(cyc), 6);
    rd(3'd0, v); chk("R11 src advanced", v, 32'h18);
    rd(3'd4, v); chk("R11 citer", v, 2);
    chk("R11 no error", {31'd0, cfg_err}, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule